// File: doc/BRIEF.md
# Locked Read-Modify-Write Swap Unit

This unit exchanges a register value with one memory location as a single indivisible operation on a simple synchronous memory bus. A command side presents a base address, a store value, a byte/word select and a one-cycle start strobe. The unit then reads the addressed location and writes the store value back to the same address. It returns the old memory contents together with a one-cycle completion pulse.

While both transfers are in flight a lock output tells the memory manager not to split them. An interrupt-inhibit output keeps pending interrupts from being taken between the read and the write. Each transfer drives address, direction and size, then holds them until the memory raises ready. The store value, address and size are captured when the start is accepted. The destination may therefore be the same register as the source, and the command inputs may change at will once the swap has begun.

The controller is a four-state machine with these states:
- `SW_IDLE`: waits for start. The transition *accept* leads to `SW_READ`.
- `SW_READ`: read transfer. It holds while ready is low. The transition *read_ack* leads to `SW_WRITE`.
- `SW_WRITE`: write transfer. It holds while ready is low. The transition *write_ack* leads to `SW_DONE`.
- `SW_DONE`: one cycle with the result pulse. The transition *retire* leads back to `SW_IDLE`.

Top module: `swap_lock_unit`

## Requirements
- R1: After reset, `busy`, `bus_rd`, `bus_wr`, `bus_lock`, `irq_inhibit` and `rsp_done` are low, and `rsp_rdata` is zero.
- R2: A `cmd_start` sampled high in idle makes `bus_rd` high in the next cycle. In that cycle `bus_addr` equals the captured `cmd_addr` and `bus_size` equals `cmd_byte`. The encoding is 0 for a word and 1 for a byte.
- R3: Each transfer holds its direction, address and size for as long as `bus_ready` is low. The cycle after a read is accepted (`bus_rd` and `bus_ready` both high), `bus_wr` is high to the same address. `bus_rd` and `bus_wr` are never high together.
- R4: `bus_lock` and `irq_inhibit` are high in every cycle in which `bus_rd` or `bus_wr` is high. Both drop in the cycle after the write is accepted.
- R5: `rsp_done` pulses high for exactly one cycle, in the cycle after the write is accepted. From that cycle on, `rsp_rdata` holds the word that was read, and it keeps that value until the next swap's read is accepted. `busy` is high from the cycle after the accepted start through the done cycle.
- R6: In byte mode (`bus_size` = 1), `bus_wdata` carries the store value's bits 7:0 with all upper bits zero. The result is the read data's bits 7:0, zero-extended.
- R7: The address, store value and size are captured at the accepted start. Changes on `cmd_addr`, `cmd_wdata` or `cmd_byte` afterwards do not change the bus transfers of that swap.
- R8: A `cmd_start` that arrives while `busy` is high is ignored. No extra transfer follows, and the running swap is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start strobe, accepted only when idle |
| cmd_addr | input | ADDR_W | Swap address |
| cmd_wdata | input | DATA_W | Value to store |
| cmd_byte | input | 1 | 1 = byte swap, 0 = word swap |
| rsp_rdata | output | DATA_W | Old memory contents |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Swap in progress |
| bus_addr | output | ADDR_W | Memory address |
| bus_rd | output | 1 | Read request |
| bus_wr | output | 1 | Write request |
| bus_size | output | 1 | 0 word, 1 byte |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with ready |
| bus_ready | input | 1 | Memory has completed the transfer |
| bus_lock | output | 1 | Read and write are locked together |
| irq_inhibit | output | 1 | Interrupts held off |

## Verification
Word swaps with zero wait states and with several wait states separate correct ready handling from a machine that advances on a fixed schedule. Byte swaps into a location whose upper bytes are non-zero show whether the result is masked and zero-extended and whether only the low byte of the store value reaches the bus. A swap during which the command inputs change and a second start is strobed tells correct capture and start filtering apart from a design that tracks the live inputs. Two swaps to the same address, back to back, confirm that the second returns exactly what the first stored.

// File: rtl/swap_pkg.sv
package swap_pkg;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_READ  = 2'd1,
        SW_WRITE = 2'd2,
        SW_DONE  = 2'd3
    } swap_state_t;

    localparam logic SIZE_WORD = 1'b0;
    localparam logic SIZE_BYTE = 1'b1;

endpackage

// File: rtl/swap_fsm.sv
module swap_fsm
    import swap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        ready,
    output swap_state_t state,
    output logic        accept,
    output logic        read_ack,
    output logic        rd_en,
    output logic        wr_en,
    output logic        lock,
    output logic        inhibit,
    output logic        done,
    output logic        busy
);

    swap_state_t state_q;
    swap_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, read_ack, write_ack, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE:  if (start) state_d = SW_READ;
            SW_READ:  if (ready) state_d = SW_WRITE;
            SW_WRITE: if (ready) state_d = SW_DONE;
            SW_DONE:  state_d = SW_IDLE;
            default:  state_d = SW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept   = 1'b0;
        read_ack = 1'b0;
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        lock     = 1'b0;
        inhibit  = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            SW_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            SW_READ: begin
                rd_en    = 1'b1;
                lock     = 1'b1;
                inhibit  = 1'b1;
                read_ack = ready;
            end
            SW_WRITE: begin
                wr_en   = 1'b1;
                lock    = 1'b1;
                inhibit = 1'b1;
            end
            SW_DONE: begin
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/swap_datapath.sv
module swap_datapath #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              read_ack,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_src,
    input  logic              in_byte,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              out_byte,
    output logic [DATA_W-1:0] result
);

    localparam int UPPER_W = DATA_W - LANE_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q;
    logic              byte_q;
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] rd_shaped;
    logic [DATA_W-1:0] wr_shaped;

    // operand capture at the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            src_q  <= '0;
            byte_q <= 1'b0;
        end else if (accept) begin
            addr_q <= in_addr;
            src_q  <= in_src;
            byte_q <= in_byte;
        end
    end

    // lane shaping: byte form keeps the low lane, zero above
    generate
        if (UPPER_W > 0) begin : g_lanes
            assign rd_shaped = byte_q ? {{UPPER_W{1'b0}}, rd_data[LANE_W-1:0]} : rd_data;
            assign wr_shaped = byte_q ? {{UPPER_W{1'b0}}, src_q[LANE_W-1:0]}   : src_q;
        end else begin : g_single
            assign rd_shaped = rd_data;
            assign wr_shaped = src_q;
        end
    endgenerate

    // result register, loaded when the read is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (read_ack) begin
            result_q <= rd_shaped;
        end
    end

    assign out_addr  = addr_q;
    assign out_wdata = wr_shaped;
    assign out_byte  = byte_q;
    assign result    = result_q;

endmodule

// File: rtl/swap_lock_unit.sv
module swap_lock_unit
    import swap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_byte,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              bus_lock,
    output logic              irq_inhibit
);

    localparam int LANE_W = 8;

    swap_state_t state;
    logic        accept;
    logic        read_ack;
    logic        size_q;

    swap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .ready    (bus_ready),
        .state    (state),
        .accept   (accept),
        .read_ack (read_ack),
        .rd_en    (bus_rd),
        .wr_en    (bus_wr),
        .lock     (bus_lock),
        .inhibit  (irq_inhibit),
        .done     (rsp_done),
        .busy     (busy)
    );

    swap_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .read_ack  (read_ack),
        .in_addr   (cmd_addr),
        .in_src    (cmd_wdata),
        .in_byte   (cmd_byte),
        .rd_data   (bus_rdata),
        .out_addr  (bus_addr),
        .out_wdata (bus_wdata),
        .out_byte  (size_q),
        .result    (rsp_rdata)
    );

    assign bus_size = size_q;

    // R3: directions exclusive
    assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R3: read stalls hold the request
    assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr) && $stable(bus_size)));

    // R3: write follows an accepted read at the same address
    assert_read_to_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ready) |=> (bus_wr && bus_addr == $past(bus_addr)));

    // R4: lock and inhibit cover every transfer
    assert_lock_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_lock && irq_inhibit));

    // R4, R5: after write acceptance, lock released and done raised
    assert_write_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ready) |=> (rsp_done && !bus_lock && !irq_inhibit));

    // R5: done is a single pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8: a start during a swap does not disturb the address
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rsp_done) |=> $stable(bus_addr));

    // R6: byte results are zero above the low lane
    assert_byte_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && bus_size == SIZE_BYTE) |-> (rsp_rdata[DATA_W-1:LANE_W] == '0));

endmodule

// File: tb/swap_lock_unit_bench.sv
module swap_lock_unit_bench;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_byte = 1'b0;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic          busy;
    logic [AW-1:0] bus_addr;
    logic          bus_rd;
    logic          bus_wr;
    logic          bus_size;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          bus_lock;
    logic          irq_inhibit;

    always #10 clk = ~clk;

    swap_lock_unit #(.ADDR_W(AW), .DATA_W(DW)) u_swap_lock_unit (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_byte(cmd_byte), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .busy(busy), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_lock(bus_lock),
        .irq_inhibit(irq_inhibit)
    );

    int nchk = 0;
    int nbad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // bench memory
    logic [DW-1:0] mem [logic [AW-1:0]];
    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    int wait_cfg = 0;
    int wcnt = 0;
    logic          pend_wr = 1'b0;
    logic [AW-1:0] pend_a;
    logic [DW-1:0] pend_d;
    logic          pend_b;

    // reference model state
    int            m_ph = 0;   // 0 idle, 1 read, 2 write, 3 done
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_src = '0;
    logic          m_byte = 1'b0;
    logic [DW-1:0] m_res = '0;
    logic          check_on = 1'b0;

    always @(negedge clk) begin
        // advance the model over the posedge just passed
        if (!rst_n) begin
            m_ph = 0; m_res = '0; m_addr = '0; m_src = '0; m_byte = 1'b0;
        end else begin
            case (m_ph)
                0: if (cmd_start) begin
                       m_addr = cmd_addr; m_src = cmd_wdata; m_byte = cmd_byte; m_ph = 1;
                   end
                1: if (bus_ready) begin
                       m_res = m_byte ? {24'h0, bus_rdata[7:0]} : bus_rdata; m_ph = 2;
                   end
                2: if (bus_ready) m_ph = 3;
                default: m_ph = 0;
            endcase
        end
        // apply a write accepted at that posedge
        if (pend_wr) begin
            if (pend_b) mem[pend_a] = {mem_rd(pend_a)[31:8], pend_d[7:0]};
            else        mem[pend_a] = pend_d;
            pend_wr = 1'b0;
        end
        // compare every cycle
        if (check_on) begin
            chk("R5 busy",        busy,        (m_ph != 0));
            chk("R2/R3 bus_rd",   bus_rd,      (m_ph == 1));
            chk("R3 bus_wr",      bus_wr,      (m_ph == 2));
            chk("R4 bus_lock",    bus_lock,    (m_ph == 1 || m_ph == 2));
            chk("R4 irq_inhibit", irq_inhibit, (m_ph == 1 || m_ph == 2));
            chk("R5 rsp_done",    rsp_done,    (m_ph == 3));
            chk("R5 rsp_rdata",   rsp_rdata,   m_res);
            if (m_ph == 1 || m_ph == 2) begin
                chk("R7 bus_addr", bus_addr, m_addr);
                chk("R6 bus_size", bus_size, m_byte);
            end
            if (m_ph == 2)
                chk("R6 bus_wdata", bus_wdata, m_byte ? {24'h0, m_src[7:0]} : m_src);
        end
        // memory response for the coming edge
        bus_ready = 1'b0;
        bus_rdata = '0;
        if (rst_n && (bus_rd || bus_wr)) begin
            if (wcnt >= wait_cfg) begin
                bus_ready = 1'b1;
                wcnt = 0;
                if (bus_rd) bus_rdata = mem_rd(bus_addr);
                if (bus_wr) begin
                    pend_wr = 1'b1; pend_a = bus_addr; pend_d = bus_wdata; pend_b = bus_size;
                end
            end else begin
                wcnt++;
            end
        end
    end

    task automatic do_swap(input logic [AW-1:0] a, input logic [DW-1:0] s,
                           input logic b, input int w, input bit disturb, input string tag);
        logic [DW-1:0] old;
        logic [DW-1:0] exp_res;
        logic [DW-1:0] exp_mem;
        int n;
        old     = mem_rd(a);
        exp_res = b ? {24'h0, old[7:0]} : old;
        exp_mem = b ? {old[31:8], s[7:0]} : s;
        wait_cfg = w;
        @(negedge clk); #1;
        cmd_start = 1'b1; cmd_addr = a; cmd_wdata = s; cmd_byte = b;
        @(negedge clk); #1;
        cmd_start = 1'b0;
        if (disturb) begin
            cmd_addr = a ^ 32'h0000_0F00; cmd_wdata = ~s; cmd_byte = ~b;
            @(negedge clk); #1;
            cmd_start = 1'b1;
            @(negedge clk); #1;
            cmd_start = 1'b0;
        end
        n = 0;
        while (rsp_done !== 1'b1 && n < 60) begin
            @(negedge clk); #3;
            n++;
        end
        chk({tag, " done seen"}, rsp_done, 1'b1);
        chk({tag, " old value"}, rsp_rdata, exp_res);
        chk({tag, " memory after"}, mem_rd(a), exp_mem);
        cmd_addr = '0; cmd_wdata = '0; cmd_byte = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk("R1 busy",   busy, 1'b0);
        chk("R1 bus_rd", bus_rd, 1'b0);
        chk("R1 bus_wr", bus_wr, 1'b0);
        chk("R1 lock",   bus_lock, 1'b0);
        chk("R1 inhibit", irq_inhibit, 1'b0);
        chk("R1 done",   rsp_done, 1'b0);
        chk("R1 rdata",  rsp_rdata, 32'h0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        check_on = 1'b1;

        mem[32'h100] = 32'h1111_2222;
        do_swap(32'h100, 32'hDEAD_BEEF, 1'b0, 0, 1'b0, "R2 R5 word w0");
        do_swap(32'h200, 32'hCAFE_F00D, 1'b0, 3, 1'b0, "R3 word w3");
        mem[32'h104] = 32'hAABB_CC7E;
        do_swap(32'h104, 32'h1234_56C3, 1'b1, 0, 1'b0, "R6 byte w0");
        mem[32'h108] = 32'h0102_03F4;
        do_swap(32'h108, 32'hFFFF_FF09, 1'b1, 2, 1'b0, "R6 byte w2");
        mem[32'h300] = 32'h7777_8888;
        do_swap(32'h300, 32'h0BAD_CAFE, 1'b0, 4, 1'b1, "R7 R8 disturbed");
        do_swap(32'h100, 32'h5555_AAAA, 1'b0, 1, 1'b0, "R5 same addr");
        do_swap(32'h100, 32'h0000_0001, 1'b0, 0, 1'b0, "R5 back to back");

        repeat (3) @(negedge clk);
        #3;
        chk("R8 idle after", busy, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule